// File: doc/BRIEF.md
# Priority Pin Crossbar

This block places the signals of a fixed set of on-chip peripherals onto a shared bank of general-purpose pads. A small configuration register selects which peripherals are enabled. Every enabled signal is assigned to the lowest pad not already taken by a signal of higher rank, so the pads of each peripheral follow on from those of the peripherals ranked above it. Enabling or disabling one peripheral therefore moves every signal ranked below it to a different pad.

Peripheral signals reach the block as flat per-signal vectors of output data, output enable and input value. Each bit of these vectors belongs to one signal slot. For each pad the block drives the data and enable of the signal assigned to it. The value of each pad is returned to the input of the signal that owns it. A pad that no signal claims is driven from the general-purpose latch and direction bits. A signal that finds no pad reads a constant 1.

Top module: `pin_xbar`

## Requirements
- R1: After reset the configuration is all-disabled: every pad drives its `gpio_latch` bit with enable from its `gpio_dir` bit, and every `sig_in` bit reads 1.
- R2: `cfg_wr_data` is loaded on a rising clock edge where `cfg_wr_en` is 1 and changes the pad mapping only after that edge. Without `cfg_wr_en` the configuration holds. The field layout is: bit 0 serial two-wire bus enable, bit 1 serial peripheral bus enable, bit 2 UART enable, bit 3 counter-clock input enable, bits 6:4 capture/compare line count.
- R3: Slots rank in this order, and the slot numbers are the bit positions in `sig_out`, `sig_oe` and `sig_in`: 0 two-wire data, 1 two-wire clock, 2 SPI clock, 3 SPI master-in, 4 SPI master-out, 5 SPI select, 6 UART transmit, 7 UART receive, 8 to 12 capture/compare lines 0 to 4, 13 counter-clock input. Each enabled slot takes the pad whose index equals the number of enabled slots ranked above it.
- R4: A capture/compare count above 5 acts as 5. A count of n enables lines 0 to n-1.
- R5: Pads assigned to UART receive and to the counter-clock input always have output enable 0. The pad of SPI master-in has output enable 0 while `spi_master` is 1, and takes `sig_oe[3]` otherwise. Every other assigned pad takes its slot's `sig_out` and `sig_oe` bits.
- R6: Each enabled slot with a pad reads that pad's `pad_in` value on its `sig_in` bit, combinationally.
- R7: A slot that is disabled or has no pad (index 16 or more) reads 1 on its `sig_in` bit.
- R8: A pad that no slot claims drives its `gpio_latch` bit, with enable from its `gpio_dir` bit.
- R9: Pad indices 0 to 7 form port 0 and 8 to 15 form port 1. With the two-wire bus, SPI, UART and counter clock enabled and no capture lines, the counter clock lands on pad 8. With the two-wire bus and counter clock only, it lands on pad 2. With SPI, UART and counter clock, it lands on pad 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 7 | Configuration value to load |
| gpio_latch | input | 16 | General-purpose output value per pad |
| gpio_dir | input | 16 | General-purpose output enable per pad |
| spi_master | input | 1 | SPI acting as master; makes master-in input-only |
| sig_out | input | 14 | Output data per signal slot |
| sig_oe | input | 14 | Output enable per signal slot |
| sig_in | output | 14 | Pad value returned per signal slot |
| pad_in | input | 16 | Value sensed on each pad |
| pad_out | output | 16 | Data driven on each pad |
| pad_oe | output | 16 | Output enable per pad |

## Verification
The mapping is tried with several enable mixes. The two-wire bus with the counter clock alone tests a small shift. SPI with UART and the counter clock tests a four-pad block ahead of a two-pad block. Three serial blocks together push the counter clock across the port boundary. UART with one capture line tests the order inside the lower-ranked group. Every slot enabled at once fills 14 of the 16 pads and leaves the top two on the general-purpose latch. A capture count of 7 run beside a count of 5 separates clamping from wrap-around. One-hot and inverted-one-hot pad inputs show that each routed input reads its own pad and no neighbouring pad.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

   // Configuration word; smb_en sits at bit 0.
   typedef struct packed {
      logic [2:0] cap_cnt;
      logic       cclk_en;
      logic       uart_en;
      logic       spi_en;
      logic       smb_en;
   } xbar_cfg_t;

   localparam int CFG_W     = $bits(xbar_cfg_t);
   localparam int CAP_CNT_W = 3;

   // Slot ranks; capture lines follow SLOT_CAP0, counter clock is last.
   localparam int SLOT_SDA   = 0;
   localparam int SLOT_SCL   = 1;
   localparam int SLOT_SCK   = 2;
   localparam int SLOT_MISO  = 3;
   localparam int SLOT_MOSI  = 4;
   localparam int SLOT_NSS   = 5;
   localparam int SLOT_TX    = 6;
   localparam int SLOT_RX    = 7;
   localparam int SLOT_CAP0  = 8;
   localparam int FIXED_SLOTS = 9;

endpackage

// File: rtl/xbar_cfg_reg.sv
module xbar_cfg_reg
   import xbar_pkg::*;
#(
   parameter int NUM_CAP = 5,
   parameter int NSLOT   = FIXED_SLOTS + NUM_CAP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  xbar_cfg_t        wr_data,
   output xbar_cfg_t        cfg_q,
   output logic [NSLOT-1:0] slot_en
);

   localparam logic [CAP_CNT_W-1:0] CAP_MAX = CAP_CNT_W'(NUM_CAP);

   logic [CAP_CNT_W-1:0] cap_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= '0;
      else if (wr_en) cfg_q <= wr_data;
   end

   assign cap_lim = (cfg_q.cap_cnt > CAP_MAX) ? CAP_MAX : cfg_q.cap_cnt;

   always_comb begin
      slot_en            = '0;
      slot_en[SLOT_SDA]  = cfg_q.smb_en;
      slot_en[SLOT_SCL]  = cfg_q.smb_en;
      slot_en[SLOT_SCK]  = cfg_q.spi_en;
      slot_en[SLOT_MISO] = cfg_q.spi_en;
      slot_en[SLOT_MOSI] = cfg_q.spi_en;
      slot_en[SLOT_NSS]  = cfg_q.spi_en;
      slot_en[SLOT_TX]   = cfg_q.uart_en;
      slot_en[SLOT_RX]   = cfg_q.uart_en;
      for (int k = 0; k < NUM_CAP; k++)
         slot_en[SLOT_CAP0+k] = (CAP_CNT_W'(k) < cap_lim);
      slot_en[NSLOT-1]   = cfg_q.cclk_en;
   end

endmodule

// File: rtl/xbar_slot_index.sv
module xbar_slot_index #(
   parameter int NSLOT = 14,
   parameter int IDX_W = 5
) (
   input  logic [NSLOT-1:0]            slot_en,
   output logic [NSLOT-1:0][IDX_W-1:0] slot_idx
);

   // Running count of enabled higher-ranked slots.
   always_comb begin
      logic [IDX_W-1:0] acc;
      acc = '0;
      for (int s = 0; s < NSLOT; s++) begin
         slot_idx[s] = acc;
         acc         = acc + IDX_W'(slot_en[s]);
      end
   end

endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux #(
   parameter int NSLOT = 14,
   parameter int NPINS = 16,
   parameter int IDX_W = 5
) (
   input  logic [NSLOT-1:0]            slot_en,
   input  logic [NSLOT-1:0][IDX_W-1:0] slot_idx,
   input  logic [NSLOT-1:0]            slot_out,
   input  logic [NSLOT-1:0]            slot_oe,
   input  logic [NPINS-1:0]            gpio_latch,
   input  logic [NPINS-1:0]            gpio_dir,
   output logic [NPINS-1:0]            pad_out,
   output logic [NPINS-1:0]            pad_oe
);

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [NSLOT-1:0] hit;

      always_comb begin
         for (int s = 0; s < NSLOT; s++)
            hit[s] = slot_en[s] && (slot_idx[s] == IDX_W'(p));
      end

      assign pad_out[p] = (|hit) ? |(hit & slot_out) : gpio_latch[p];
      assign pad_oe[p]  = (|hit) ? |(hit & slot_oe)  : gpio_dir[p];
   end

endmodule

// File: rtl/xbar_in_route.sv
module xbar_in_route #(
   parameter int NSLOT = 14,
   parameter int NPINS = 16,
   parameter int IDX_W = 5,
   parameter int PIN_W = 4
) (
   input  logic [NSLOT-1:0]            slot_en,
   input  logic [NSLOT-1:0][IDX_W-1:0] slot_idx,
   input  logic [NPINS-1:0]            pad_in,
   output logic [NSLOT-1:0]            slot_in
);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic placed;
      assign placed     = slot_en[s] && (slot_idx[s] < IDX_W'(NPINS));
      assign slot_in[s] = placed ? pad_in[slot_idx[s][PIN_W-1:0]] : 1'b1;
   end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
   import xbar_pkg::*;
#(
   parameter int  NUM_PORTS = 2,
   parameter int  PORT_W    = 8,
   parameter int  NUM_CAP   = 5,
   localparam int NPINS     = NUM_PORTS * PORT_W,
   localparam int NSLOT     = FIXED_SLOTS + NUM_CAP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wr_data,
   input  logic [NPINS-1:0] gpio_latch,
   input  logic [NPINS-1:0] gpio_dir,
   input  logic             spi_master,
   input  logic [NSLOT-1:0] sig_out,
   input  logic [NSLOT-1:0] sig_oe,
   output logic [NSLOT-1:0] sig_in,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);

   localparam int MAX_IDX = (NPINS > NSLOT) ? NPINS : NSLOT;
   localparam int IDX_W   = $clog2(MAX_IDX + 1);
   localparam int PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1;

   if (NUM_CAP < 1 || NUM_CAP >= (1 << CAP_CNT_W)) begin : g_bad_cap
      $error("pin_xbar: NUM_CAP out of range for the count field");
   end
   if (NUM_PORTS < 1 || PORT_W < 1) begin : g_bad_port
      $error("pin_xbar: port geometry must be non-zero");
   end

   xbar_cfg_t                  cfg_q;
   logic [NSLOT-1:0]           slot_en;
   logic [NSLOT-1:0][IDX_W-1:0] slot_idx;
   logic [NSLOT-1:0]           eff_oe;

   xbar_cfg_reg #(.NUM_CAP(NUM_CAP), .NSLOT(NSLOT)) i_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (xbar_cfg_t'(cfg_wr_data)),
      .cfg_q   (cfg_q),
      .slot_en (slot_en)
   );

   xbar_slot_index #(.NSLOT(NSLOT), .IDX_W(IDX_W)) i_index (
      .slot_en  (slot_en),
      .slot_idx (slot_idx)
   );

   // Input-only slots never drive their pad.
   always_comb begin
      eff_oe           = sig_oe;
      eff_oe[SLOT_RX]  = 1'b0;
      eff_oe[NSLOT-1]  = 1'b0;
      if (spi_master) eff_oe[SLOT_MISO] = 1'b0;
   end

   xbar_pin_mux #(.NSLOT(NSLOT), .NPINS(NPINS), .IDX_W(IDX_W)) i_mux (
      .slot_en    (slot_en),
      .slot_idx   (slot_idx),
      .slot_out   (sig_out),
      .slot_oe    (eff_oe),
      .gpio_latch (gpio_latch),
      .gpio_dir   (gpio_dir),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe)
   );

   xbar_in_route #(.NSLOT(NSLOT), .NPINS(NPINS), .IDX_W(IDX_W), .PIN_W(PIN_W)) i_route (
      .slot_en  (slot_en),
      .slot_idx (slot_idx),
      .pad_in   (pad_in),
      .slot_in  (sig_in)
   );

endmodule

// File: rtl/xbar_checks.sv
module xbar_checks
   import xbar_pkg::*;
#(
   parameter int NSLOT = 14,
   parameter int NPINS = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr_en,
   input xbar_cfg_t        cfg_q,
   input logic [NPINS-1:0] pad_in,
   input logic [NPINS-1:0] pad_out,
   input logic [NPINS-1:0] pad_oe,
   input logic [NPINS-1:0] gpio_latch,
   input logic [NPINS-1:0] gpio_dir,
   input logic [NSLOT-1:0] sig_out,
   input logic [NSLOT-1:0] sig_oe,
   input logic [NSLOT-1:0] sig_in
);

   int rx_pad;
   int cclk_pad;

   assign rx_pad   = (cfg_q.smb_en ? 2 : 0) + (cfg_q.spi_en ? 4 : 0) + 1;
   assign cclk_pad = (cfg_q.smb_en ? 2 : 0) + (cfg_q.spi_en ? 4 : 0) + (cfg_q.uart_en ? 2 : 0);

   assert_gpio_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q == '0) |-> (pad_out == gpio_latch && pad_oe == gpio_dir && (&sig_in)));

   assert_cfg_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr_en |=> $stable(cfg_q));

   assert_smb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.smb_en |-> (pad_out[1:0] == sig_out[1:0] && pad_oe[1:0] == sig_oe[1:0]));

   assert_rx_input_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.uart_en |-> !pad_oe[rx_pad]);

   assert_cclk_routed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.cclk_en && cfg_q.cap_cnt == '0) |-> (sig_in[NSLOT-1] == pad_in[cclk_pad] && !pad_oe[cclk_pad]));

endmodule

bind pin_xbar xbar_checks #(.NSLOT(NSLOT), .NPINS(NPINS)) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr_en  (cfg_wr_en),
   .cfg_q      (cfg_q),
   .pad_in     (pad_in),
   .pad_out    (pad_out),
   .pad_oe     (pad_oe),
   .gpio_latch (gpio_latch),
   .gpio_dir   (gpio_dir),
   .sig_out    (sig_out),
   .sig_oe     (sig_oe),
   .sig_in     (sig_in)
);

// File: tb/test_pin_xbar.sv
module test_pin_xbar;

   localparam int NP = 16;
   localparam int NS = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [6:0]    cfg_wr_data = '0;
   logic [NP-1:0] gpio_latch = 16'hA5C3;
   logic [NP-1:0] gpio_dir = 16'h0FF0;
   logic          spi_master = 1'b0;
   logic [NS-1:0] sig_out = 14'h2A5B;
   logic [NS-1:0] sig_oe = 14'h3FFF;
   logic [NS-1:0] sig_in;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;

   int checks = 0;
   int errors = 0;
   logic [6:0] cur_cfg = '0;
   bit done = 0;

   always #5 clk = ~clk;

   pin_xbar i_pin_xbar (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .gpio_latch(gpio_latch), .gpio_dir(gpio_dir), .spi_master(spi_master),
      .sig_out(sig_out), .sig_oe(sig_oe), .sig_in(sig_in),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [6:0] v);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_data = v;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
      cur_cfg     = v;
      #1;
   endtask

   // Reference mapping built from the requirement text.
   task automatic check_all(input string rq);
      logic [NS-1:0] en;
      logic [NP-1:0] eo, eoe;
      logic [NS-1:0] ein;
      int lim, idx;
      logic oe_s;
      lim = (cur_cfg[6:4] > 5) ? 5 : int'(cur_cfg[6:4]);
      en = '0;
      en[1:0] = {2{cur_cfg[0]}};
      en[5:2] = {4{cur_cfg[1]}};
      en[7:6] = {2{cur_cfg[2]}};
      for (int k = 0; k < 5; k++) en[8+k] = (k < lim);
      en[13] = cur_cfg[3];
      eo = gpio_latch; eoe = gpio_dir; ein = '1; idx = 0;
      for (int s = 0; s < NS; s++) begin
         if (en[s]) begin
            oe_s = sig_oe[s];
            if (s == 7 || s == 13 || (s == 3 && spi_master)) oe_s = 1'b0;
            if (idx < NP) begin
               eo[idx]  = sig_out[s];
               eoe[idx] = oe_s;
               ein[s]   = pad_in[idx];
            end
            idx++;
         end
      end
      chk(rq, "pad_out", 32'(pad_out), 32'(eo));
      chk(rq, "pad_oe",  32'(pad_oe),  32'(eoe));
      chk(rq, "sig_in",  32'(sig_in),  32'(ein));
   endtask

   task automatic cclk_at(input string rq, input int pad);
      pad_in = 16'h0001 << pad; #1;
      chk(rq, "cclk pad one-hot", 32'(sig_in[13]), 32'd1);
      pad_in = ~(16'h0001 << pad); #1;
      chk(rq, "cclk pad inverted", 32'(sig_in[13]), 32'd0);
      chk(rq, "cclk pad oe", 32'(pad_oe[pad]), 32'd0);
   endtask

   task automatic t_reset;
      #1;
      chk("R1", "pad_out", 32'(pad_out), 32'(gpio_latch));
      chk("R1", "pad_oe", 32'(pad_oe), 32'(gpio_dir));
      chk("R1", "sig_in", 32'(sig_in), 32'h3FFF);
      check_all("R1");
   endtask

   task automatic t_write_timing;
      pad_in = '0;
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_data = 7'b000_1001;
      #1;
      chk("R2", "before edge cclk unplaced", 32'(sig_in[13]), 32'd1);
      @(negedge clk);
      cfg_wr_en = 1'b0; cur_cfg = 7'b000_1001;
      #1;
      chk("R2", "after edge cclk placed", 32'(sig_in[13]), 32'd0);
      cfg_wr_data = 7'b000_0000;
      @(negedge clk); @(negedge clk); #1;
      chk("R2", "no strobe holds cfg", 32'(sig_in[13]), 32'd0);
      check_all("R2");
   endtask

   task automatic t_smb_cclk;
      write_cfg(7'b000_1001);
      cclk_at("R9", 2);
      check_all("R3");
   endtask

   task automatic t_spi_uart_cclk;
      write_cfg(7'b000_1110);
      cclk_at("R9", 6);
      pad_in = 16'h00A6; #1;
      check_all("R6");
   endtask

   task automatic t_port_cross;
      write_cfg(7'b000_1111);
      cclk_at("R9", 8);
      check_all("R9");
   endtask

   task automatic t_uart_cap;
      write_cfg(7'b001_1100);
      sig_out = 14'h0140; #1;
      chk("R3", "tx on pad 0", 32'(pad_out[0]), 32'd1);
      chk("R3", "cap0 on pad 2", 32'(pad_out[2]), 32'd1);
      cclk_at("R3", 3);
      sig_out = 14'h2A5B; #1;
      check_all("R3");
   endtask

   task automatic t_clamp;
      write_cfg(7'b111_1000);
      cclk_at("R4", 5);
      check_all("R4");
      write_cfg(7'b101_1000);
      cclk_at("R4", 5);
   endtask

   task automatic t_input_only;
      sig_oe = '1;
      write_cfg(7'b000_0110);
      spi_master = 1'b1; #1;
      chk("R5", "miso oe as master", 32'(pad_oe[1]), 32'd0);
      chk("R5", "rx oe", 32'(pad_oe[5]), 32'd0);
      chk("R5", "tx oe", 32'(pad_oe[4]), 32'd1);
      check_all("R5");
      spi_master = 1'b0; #1;
      chk("R5", "miso oe as slave", 32'(pad_oe[1]), 32'd1);
      check_all("R5");
   endtask

   task automatic t_default_one;
      pad_in = '0;
      write_cfg(7'b000_0001);
      chk("R7", "cclk disabled reads 1", 32'(sig_in[13]), 32'd1);
      chk("R7", "uart rx disabled reads 1", 32'(sig_in[7]), 32'd1);
      chk("R6", "sda routed", 32'(sig_in[0]), 32'd0);
      check_all("R7");
   endtask

   task automatic t_gpio_rest;
      write_cfg(7'b000_0001);
      gpio_latch = 16'h3C5A; gpio_dir = 16'hF00F; #1;
      chk("R8", "free pads latch", 32'(pad_out[15:2]), 32'(gpio_latch[15:2]));
      chk("R8", "free pads dir", 32'(pad_oe[15:2]), 32'(gpio_dir[15:2]));
      write_cfg(7'b101_1111);
      pad_in = 16'h9C35; sig_oe = 14'h1B2D; #1;
      chk("R8", "top pads latch", 32'(pad_out[15:14]), 32'(gpio_latch[15:14]));
      check_all("R8");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_timing();
      t_smb_cclk();
      t_spi_uart_cclk();
      t_port_cross();
      t_uart_cap();
      t_clamp();
      t_input_only();
      t_default_one();
      t_gpio_rest();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule